// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM that is 16 bits wide, has an 18-bit word address and separate strobes for its low and high byte. The host issues one read or one write at a time with a single-cycle request, qualified by a ready flag. The controller then plays out a strobe sequence in which every phase lasts a whole number of clock cycles. The phase lengths are derived when the design is elaborated, from a clock-period parameter and the memory's nanosecond timing limits.

Every access follows the same pattern. The address is set up while all strobes are inactive. The access phase follows, and then a recovery cycle with all strobes inactive. During a write, output enable stays inactive throughout. The controller turns its own data drivers on only after the memory's outputs are guaranteed released, and keeps them on for one cycle after the write strobe ends. A read captures the bus on the last cycle of the access phase and returns it with a one-cycle valid pulse. The byte mask selects which lanes take part, and lanes that are masked off read back as zero.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, chip enable, write enable, output enable and both lane strobes are high (inactive), the data drivers are off, ready is high and the read-valid flag is low.
- R2: During a read, chip enable and output enable are low and write enable is high. The low-lane strobe (data bits 7:0) is low only if mask bit 0 is set, and the high-lane strobe (bits 15:8) only if mask bit 1 is set. Returned data carries the memory's byte for each enabled lane and zero for each disabled lane.
- R3: A read's access phase lasts ceil(55 ns / clock period) cycles. The bus is captured on the final cycle of that phase. Read-valid is high for exactly one cycle, the cycle after capture, and never fires for a write.
- R4: During a write, chip enable and write enable are low and output enable stays high. Only lanes whose mask bit is set are written, and every other byte of memory keeps its value.
- R5: Write enable stays low for at least the largest of ceil(45 ns/T), ceil(20 ns/T)+ceil(25 ns/T) and ceil(50 ns/T)-1 cycles. The data drivers stay off for the first ceil(20 ns/T) of those cycles, then stay on until write enable rises, and turn off one cycle after that. The drivers are never on while output enable is low.
- R6: The memory address changes only while all four strobes are high. Every access is preceded by at least one all-high cycle after the address is set, and followed by at least one all-high cycle.
- R7: Ready falls on the cycle after a request is accepted and stays low until the controller is idle again. Request inputs that arrive while ready is low are ignored, and the values of the accepted request are used.
- R8: A request with mask 00 runs the full timing sequence but drives neither lane strobe, so no write or read takes place. A read with mask 00 returns zero.
- R9: With a 10 ns clock, a read keeps ready low for 8 cycles and a write for 7 cycles (one setup, access phase, one recovery). Each phase takes at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Lane mask: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready_o | output | 1 | Idle and able to accept a request |
| rdata_o | output | 16 | Read data, masked lanes zero |
| rvalid_o | output | 1 | One-cycle read-data-valid pulse |
| sram_addr_o | output | 18 | Memory address |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_lb_no | output | 1 | Low-lane strobe, active low |
| sram_ub_no | output | 1 | High-lane strobe, active low |
| sram_dq_o | output | 16 | Data to memory |
| sram_dq_oe_o | output | 1 | Data driver enable |
| sram_dq_i | input | 16 | Data from memory |

## Verification
A corrupted state or phase counter shows at the pins within the same access: the busy span differs from 7 or 8 cycles, or the read-valid pulse lands on the wrong cycle. A read sampled too early picks up filler data that the memory model returns before its access time has passed, and a wrong lane decode shows on the next read-back of that address. Bus faults show on the cycle they happen: drivers on while output enable is low, an address change under an active strobe, or a write pulse or data window that is too short.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RD,
    ST_WR,
    ST_REC
  } sram_st_e;

  // whole cycles covering ns, never below one
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int RD_CYC    = 6,
  parameter int WP_CYC    = 5,
  parameter int REC_CYC   = 1,
  parameter int CNT_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             op_we_i,
  output sram_st_e         state_q_o,
  output sram_st_e         state_d_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             accept_o,
  output logic             rd_last_o
);

  sram_st_e         state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    accept_o  = 1'b0;
    rd_last_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          state_d  = ST_SETUP;
          cnt_d    = CNT_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (cnt_zero) begin
          state_d = op_we_i ? ST_WR : ST_RD;
          cnt_d   = op_we_i ? CNT_W'(WP_CYC - 1) : CNT_W'(RD_CYC - 1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_RD: begin
        if (cnt_zero) begin
          rd_last_o = 1'b1;
          state_d   = ST_REC;
          cnt_d     = CNT_W'(REC_CYC - 1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_WR: begin
        if (cnt_zero) begin
          state_d = ST_REC;
          cnt_d   = CNT_W'(REC_CYC - 1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_REC: begin
        if (cnt_zero) state_d = ST_IDLE;
        else          cnt_d   = cnt_q - CNT_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
  assign cnt_d_o   = cnt_d;

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int WP_CYC    = 5,
  parameter int WHZ_CYC   = 2,
  parameter int REC_CYC   = 1,
  parameter int CNT_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  sram_st_e             state_d_i,
  input  logic [CNT_W-1:0]     cnt_d_i,
  input  logic                 op_we_i,
  input  logic [NUM_LANES-1:0] be_i,
  output logic                 ce_no,
  output logic                 we_no,
  output logic                 oe_no,
  output logic [NUM_LANES-1:0] lane_no,
  output logic                 dq_oe_o
);

  localparam int DRV_CYC = WP_CYC - WHZ_CYC;

  logic act_d, drv_d;

  assign act_d = (state_d_i == ST_RD) || (state_d_i == ST_WR);
  // drivers wait out the memory's release time, then hold one cycle past the write
  assign drv_d = ((state_d_i == ST_WR) && (cnt_d_i < CNT_W'(DRV_CYC))) ||
                 ((state_d_i == ST_REC) && op_we_i && (cnt_d_i == CNT_W'(REC_CYC - 1)));

  // all pins come from flops so the asynchronous part never sees decode glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_no   <= 1'b1;
      we_no   <= 1'b1;
      oe_no   <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      ce_no   <= !act_d;
      we_no   <= (state_d_i != ST_WR);
      oe_no   <= (state_d_i != ST_RD);
      dq_oe_o <= drv_d;
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_no[g] <= 1'b1;
      else         lane_no[g] <= !(act_d && be_i[g]);
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cap_i,
  input  logic [NUM_LANES-1:0]        be_i,
  input  logic [NUM_LANES*LANE_W-1:0] dq_i,
  output logic [NUM_LANES*LANE_W-1:0] rdata_o,
  output logic                        rvalid_o
);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdata_o[g*LANE_W +: LANE_W] <= '0;
      end else if (cap_i) begin
        rdata_o[g*LANE_W +: LANE_W] <= be_i[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_o <= 1'b0;
    else         rvalid_o <= cap_i;
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_AS_NS       = 0,
  parameter int T_ACC_NS      = 55,
  parameter int T_WP_NS       = 45,
  parameter int T_AW_NS       = 50,
  parameter int T_DW_NS       = 25,
  parameter int T_WHZ_NS      = 20,
  parameter int T_TURN_NS     = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        be_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic              sram_lb_no,
  output logic              sram_ub_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int NUM_LANES = DATA_W / 8;
  localparam int SETUP_CYC = ns_to_cyc(T_AS_NS, CLK_PERIOD_NS);
  localparam int RD_CYC    = ns_to_cyc(T_ACC_NS, CLK_PERIOD_NS);
  localparam int WHZ_CYC   = ns_to_cyc(T_WHZ_NS, CLK_PERIOD_NS);
  localparam int DW_CYC    = ns_to_cyc(T_DW_NS, CLK_PERIOD_NS);
  localparam int REC_CYC   = ns_to_cyc(T_TURN_NS, CLK_PERIOD_NS);
  localparam int WP_CYC    = max_int(max_int(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS), WHZ_CYC + DW_CYC),
                                     ns_to_cyc(T_AW_NS, CLK_PERIOD_NS) - SETUP_CYC);
  localparam int MAX_CYC   = max_int(max_int(RD_CYC, WP_CYC), max_int(SETUP_CYC, REC_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  sram_st_e             state_q, state_d;
  logic [CNT_W-1:0]     cnt_d;
  logic                 accept, rd_last;
  logic                 op_we_q;
  logic [NUM_LANES-1:0] be_q, lane_n;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;

  // request fields are frozen at acceptance, while every strobe is inactive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_we_q <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_we_q <= we_i;
      be_q    <= NUM_LANES'(be_i);
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  sram_ctrl_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .RD_CYC    (RD_CYC),
    .WP_CYC    (WP_CYC),
    .REC_CYC   (REC_CYC),
    .CNT_W     (CNT_W)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .op_we_i   (op_we_q),
    .state_q_o (state_q),
    .state_d_o (state_d),
    .cnt_d_o   (cnt_d),
    .accept_o  (accept),
    .rd_last_o (rd_last)
  );

  sram_pin_drive #(
    .NUM_LANES (NUM_LANES),
    .WP_CYC    (WP_CYC),
    .WHZ_CYC   (WHZ_CYC),
    .REC_CYC   (REC_CYC),
    .CNT_W     (CNT_W)
  ) i_pins (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .cnt_d_i   (cnt_d),
    .op_we_i   (op_we_q),
    .be_i      (be_q),
    .ce_no     (sram_ce_no),
    .we_no     (sram_we_no),
    .oe_no     (sram_oe_no),
    .lane_no   (lane_n),
    .dq_oe_o   (sram_dq_oe_o)
  );

  sram_rd_capture #(
    .NUM_LANES (NUM_LANES),
    .LANE_W    (8)
  ) i_rdcap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (rd_last),
    .be_i      (be_q),
    .dq_i      (sram_dq_i),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  assign ready_o     = (state_q == ST_IDLE);
  assign sram_addr_o = addr_q;
  assign sram_dq_o   = wdata_q;
  assign sram_lb_no  = lane_n[0];
  assign sram_ub_no  = lane_n[NUM_LANES-1];

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int WP_CYC = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic              sram_lb_no,
  input logic              sram_ub_no,
  input logic              sram_dq_oe_o
);

  logic [7:0] we_low_cnt;
  logic       all_high;

  assign all_high = sram_ce_no && sram_we_no && sram_lb_no && sram_ub_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          we_low_cnt <= '0;
    else if (!sram_we_no) we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1;
    else                  we_low_cnt <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (all_high && sram_oe_no && !sram_dq_oe_o));

  p_rvalid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  p_oe_off_in_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_oe_no);

  p_no_bus_fight_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);

  p_wp_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (we_low_cnt >= 8'(WP_CYC)));

  p_addr_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_addr_o != $past(sram_addr_o)) |-> all_high);

  p_gap_after_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_ce_no) |=> sram_ce_no);

  p_busy_low_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_ce_no |-> !ready_o);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .WP_CYC (WP_CYC)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .rvalid_o     (rvalid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_lb_no   (sram_lb_no),
  .sram_ub_no   (sram_ub_no),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  localparam int PER     = 10;
  localparam int RD_EXP  = (55 + PER - 1) / PER;
  localparam int WHZ_EXP = (20 + PER - 1) / PER;
  localparam int DW_EXP  = (25 + PER - 1) / PER;
  localparam int WP_A    = (45 + PER - 1) / PER;
  localparam int WP_B    = WHZ_EXP + DW_EXP;
  localparam int WP_C    = (50 + PER - 1) / PER - 1;
  localparam int WP_AB   = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int WP_EXP  = (WP_AB > WP_C) ? WP_AB : WP_C;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [17:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [1:0]  be_i = '0;
  logic        ready_o, rvalid_o;
  logic [15:0] rdata_o;
  logic [17:0] sram_addr_o;
  logic        sram_ce_no, sram_we_no, sram_oe_no, sram_lb_no, sram_ub_no;
  logic [15:0] sram_dq_o;
  logic        sram_dq_oe_o;
  logic [15:0] sram_dq_i = 16'hA5A5;

  always #5 clk_i = ~clk_i;

  sram_async_ctrl i_sram_async_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .be_i,
    .ready_o, .rdata_o, .rvalid_o,
    .sram_addr_o, .sram_ce_no, .sram_we_no, .sram_oe_no, .sram_lb_no, .sram_ub_no,
    .sram_dq_o, .sram_dq_oe_o, .sram_dq_i
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model and pin monitor
  logic [15:0] mem_m [int];
  logic [15:0] ref_m [int];

  function automatic logic [15:0] mem_rd(input int a);
    return mem_m.exists(a) ? mem_m[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] ref_rd(input int a);
    return ref_m.exists(a) ? ref_m[a] : 16'h0000;
  endfunction

  int          wlow = 0, wdrv = 0, rdcnt = 0, commits = 0;
  int          viol_addr = 0, viol_fight = 0, viol_oe = 0, viol_rel = 0;
  logic        prev_wact = 1'b0, chk_rel = 1'b0;
  logic [1:0]  prev_lanes = 2'b00;
  logic [15:0] prev_data = '0;
  logic [17:0] prev_addr = '0, last_addr = '0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic wact, ract;
      logic [15:0] cur;
      wact = !sram_ce_no && !sram_we_no && (!sram_lb_no || !sram_ub_no);
      ract = !sram_ce_no && sram_we_no && !sram_oe_no && (!sram_lb_no || !sram_ub_no);
      if (sram_addr_o != last_addr && !(sram_ce_no && sram_we_no && sram_lb_no && sram_ub_no))
        viol_addr++;
      last_addr = sram_addr_o;
      if (sram_dq_oe_o && !sram_oe_no) viol_fight++;
      if (!sram_we_no && !sram_oe_no) viol_oe++;
      if (chk_rel) begin
        if (sram_dq_oe_o) viol_rel++;
        chk_rel = 1'b0;
      end
      if (wact) begin
        wlow++;
        if (sram_dq_oe_o) wdrv++;
        else              wdrv = 0;
        prev_lanes = {!sram_ub_no, !sram_lb_no};
        prev_data  = sram_dq_o;
        prev_addr  = sram_addr_o;
      end else if (prev_wact) begin
        check("R5 write pulse cycles", wlow >= WP_EXP, 1);
        check("R5 data window before write end", wdrv >= DW_EXP, 1);
        check("R5 drivers off while memory releases", (wlow - wdrv) >= WHZ_EXP, 1);
        check("R5 drivers held after write end", sram_dq_oe_o, 1'b1);
        chk_rel = 1'b1;
        cur = mem_rd(int'(prev_addr));
        if (prev_lanes[0]) cur[7:0]  = prev_data[7:0];
        if (prev_lanes[1]) cur[15:8] = prev_data[15:8];
        mem_m[int'(prev_addr)] = cur;
        commits++;
        wlow = 0;
        wdrv = 0;
      end
      prev_wact = wact;
      if (ract) rdcnt++;
      else      rdcnt = 0;
      cur = mem_rd(int'(sram_addr_o));
      sram_dq_i[7:0]  <= (ract && !sram_lb_no) ? ((rdcnt >= RD_EXP) ? cur[7:0]  : 8'hEE) : 8'hA5;
      sram_dq_i[15:8] <= (ract && !sram_ub_no) ? ((rdcnt >= RD_EXP) ? cur[15:8] : 8'hEE) : 8'hA5;
    end
  end

  task automatic access(input logic w, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m, output int busy, output int rv_at,
                        output int rv_cnt, output logic [15:0] rd);
    while (!ready_o) @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d; be_i = m;
    @(negedge clk_i);
    // R7: inputs change under a held request and must be ignored
    we_i = ~w; addr_i = ~a; wdata_i = ~d; be_i = ~m;
    busy = 0; rv_at = -1; rv_cnt = 0; rd = '0;
    while (!ready_o) begin
      busy++;
      if (rvalid_o) begin
        rv_at = busy; rv_cnt++; rd = rdata_o;
      end
      @(negedge clk_i);
    end
    req_i = 1'b0;
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [17:0] addrs [6];
    int busy, rv_at, rv_cnt, n_wr_exp;
    logic [15:0] rd, d, e;
    addrs[0] = 18'h00000; addrs[1] = 18'h00001; addrs[2] = 18'h2AAAA;
    addrs[3] = 18'h15555; addrs[4] = 18'h3FFFF; addrs[5] = 18'h00100;
    n_wr_exp = 0;

    repeat (3) @(negedge clk_i);
    // R1: reset values
    check("R1 ready in reset", ready_o, 1'b1);
    check("R1 strobes in reset", {sram_ce_no, sram_we_no, sram_oe_no, sram_lb_no, sram_ub_no}, 5'b11111);
    check("R1 drivers off in reset", sram_dq_oe_o, 1'b0);
    check("R1 no valid in reset", rvalid_o, 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 idle strobes", {sram_ce_no, sram_we_no, sram_oe_no, sram_lb_no, sram_ub_no, sram_dq_oe_o}, 6'b111110);

    for (int ai = 0; ai < 6; ai++) begin
      for (int wm = 0; wm < 4; wm++) begin
        d = addrs[ai][15:0] ^ 16'hC3A5 ^ {8{wm[1:0]}};
        access(1'b1, addrs[ai], d, wm[1:0], busy, rv_at, rv_cnt, rd);
        check("R9 write busy cycles", busy, WP_EXP + 2);
        check("R3 no valid on write", rv_cnt, 0);
        e = ref_rd(int'(addrs[ai]));
        e = (e & ~lane_mask(wm[1:0])) | (d & lane_mask(wm[1:0]));
        ref_m[int'(addrs[ai])] = e;
        if (wm != 0) n_wr_exp++;
        for (int rm = 0; rm < 4; rm++) begin
          access(1'b0, addrs[ai], 16'h0, rm[1:0], busy, rv_at, rv_cnt, rd);
          check("R9 read busy cycles", busy, RD_EXP + 2);
          check("R3 valid cycle", rv_at, RD_EXP + 2);
          check("R3 single valid pulse", rv_cnt, 1);
          if (wm == 0 || rm == 0)
            check("R8 masked request data", rd, ref_rd(int'(addrs[ai])) & lane_mask(rm[1:0]));
          else
            check("R2 R4 lane read-back", rd, ref_rd(int'(addrs[ai])) & lane_mask(rm[1:0]));
        end
      end
    end

    for (int ai = 0; ai < 6; ai++)
      check("R4 memory contents", mem_rd(int'(addrs[ai])), ref_rd(int'(addrs[ai])));
    check("R7 R8 number of writes reaching memory", commits, n_wr_exp);
    check("R6 address change under strobe", viol_addr, 0);
    check("R4 output enable low during write", viol_oe, 0);
    check("R5 drivers on with output enable low", viol_fight, 0);
    check("R5 drivers released after write", viol_rel, 0);
    check("R1 idle at end", {ready_o, sram_ce_no, sram_dq_oe_o}, 3'b110);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule